// File: doc/BRIEF.md
# Programmable Clock Generator with Binary and Integer Division

This block derives a generated clock from one source clock. A single 16-bit divide field serves two division modes. In binary mode the field holds an exponent. In integer mode it holds the divisor itself, and a divisor of 0 or 1 passes the source through unchanged. For odd integer divisors an optional duty correction stretches the high phase by half a source period. The result comes out close to 50 %.

A generator enable starts and stops the clock, and a standby request stops it too unless a run-in-standby bit is set. The block only ever stops at the end of a whole output period, so a stop never cuts a pulse short. While the generator is stopped, the clock output holds a programmable level. An activity flag stays high until the output has really come to rest. A pad-enable bit decides whether the generated clock also appears on a pad output. All settings are sampled when a period begins. A change made while the generator runs therefore takes effect at the next period boundary.

Top module: `gcd_gen`

## Requirements
- R1: With `bin_mode`=1 the exponent e is `div_val[4:0]`, and bits 15:5 are ignored. The output period is 2^(e+1) source cycles, high for the first 2^e of them. `div_val`=0 therefore divides by 2, not by 1.
- R2: With `bin_mode`=0, `duty_fix`=0 and N=`div_val`>=2, the output period is N source cycles and the high phase is floor(N/2) source cycles.
- R3: With `bin_mode`=0 and `div_val` equal to 0 or 1, the running output follows the source clock (high half, low half).
- R4: With `bin_mode`=0, `duty_fix`=1 and an odd N>=3, the high phase is N/2 source cycles: floor(N/2) cycles plus one source half period. For even N the high phase stays N/2 cycles.
- R5: While the generator is stopped, `gclk_o` equals `off_level`.
- R6: `pad_clk_o` equals `gclk_o` when `pad_en`=1 and is 0 when `pad_en`=0.
- R7: `gen_active_o` rises within two source cycles of `gen_en` going high. After `gen_en` falls it stays 1 until the output has stopped, at most one output period plus two source cycles later, and then reads 0.
- R8: While `stby_req`=1, the generator stops if `stby_run`=0 and keeps running with unchanged waveform if `stby_run`=1.
- R9: During and after a synchronous active-low reset, `gen_active_o`=0 and `gclk_o` equals `off_level`.
- R10: A stop takes effect only at a period boundary: a high pulse that has begun completes its full width. Settings are sampled at the start of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_val | input | 16 | Divide field (exponent or integer divisor) |
| bin_mode | input | 1 | 1 = binary power-of-two mode, 0 = integer mode |
| duty_fix | input | 1 | Half-cycle high stretch for odd integer divisors |
| off_level | input | 1 | Output level while stopped |
| pad_en | input | 1 | Gates the generated clock onto the pad output |
| gen_en | input | 1 | Generator enable |
| stby_req | input | 1 | Standby request |
| stby_run | input | 1 | Keep running during standby |
| gclk_o | output | 1 | Generated clock |
| pad_clk_o | output | 1 | Pad copy of the generated clock |
| gen_active_o | output | 1 | 1 while the generator has not yet come to rest |

## Verification
The hardest case to reach is a disable that arrives in the middle of a high pulse. The block must then finish that pulse at full width and hold the activity flag until the output is idle. The stimulus waits for the output to rise, clears the enable in that same half cycle, and then measures the remaining high width in half-cycle samples. It also counts the cycles until the flag drops. The half-period stretch is only visible between source edges, so every waveform measurement samples the output in both halves of each source cycle.

// File: rtl/gcd_pkg.sv
// Shared constants and configuration type for the clock generator.
package gcd_pkg;
    localparam int DIV_W = 16;                  // width of the divide field
    localparam int EXP_W = 5;                   // exponent bits used in binary mode
    localparam int CNT_W = (1 << EXP_W) + 1;    // phase counter wide enough for 2^(2^EXP_W)
    localparam int SH_W  = $clog2(CNT_W);

    typedef struct packed {
        logic             bin_mode;
        logic             duty_fix;
        logic [DIV_W-1:0] div;
    } gcd_cfg_t;
endpackage

// File: rtl/gcd_run_ctrl.sv
// Run control: decides whether the next output period is produced.
// Assumes wrap_i pulses on the last source cycle of each running period.
module gcd_run_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic gen_en,
    input  logic stby_req,
    input  logic stby_run,
    input  logic wrap_i,
    output logic run_q
);
    logic go;

    // Run is wanted when enabled and not held off by standby.
    always_comb go = gen_en && !(stby_req && !stby_run);

    // Start from idle at once, stop only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)               run_q <= 1'b0;
        else if (!run_q || wrap_i) run_q <= go;
    end

    AST_STOP_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> $past(wrap_i)); // R10
endmodule

// File: rtl/gcd_phase_cnt.sv
// Phase counter: counts source cycles within a period and forms the
// registered divided level. Settings are captured at period starts.
// Assumes run_q comes from gcd_run_ctrl and changes only at boundaries.
module gcd_phase_cnt
    import gcd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run_q,
    input  gcd_cfg_t cfg_i,
    output logic     wrap_o,
    output logic     div_q,
    output logic     live_q,
    output logic     pass_o,
    output logic     odd_fix_o
);
    gcd_cfg_t               cfg_q;
    logic [CNT_W-1:0]       cnt;
    logic [CNT_W-1:0]       last;
    logic [CNT_W-1:0]       half;
    logic [EXP_W-1:0]       expo;
    logic [SH_W-1:0]        sh;
    logic [CNT_W-1:0]       ones;

    // Period length and high length from the captured settings.
    always_comb begin
        expo      = cfg_q.div[EXP_W-1:0];
        ones      = '1;
        sh        = SH_W'(CNT_W - 1) - SH_W'(expo);
        pass_o    = !cfg_q.bin_mode && (cfg_q.div <= DIV_W'(1));
        odd_fix_o = !cfg_q.bin_mode && cfg_q.duty_fix && cfg_q.div[0] && !pass_o;
        if (cfg_q.bin_mode) begin
            last = ones >> sh;
            half = CNT_W'(1) << expo;
        end else if (pass_o) begin
            last = '0;
            half = CNT_W'(1);
        end else begin
            last = CNT_W'(cfg_q.div) - CNT_W'(1);
            half = CNT_W'(cfg_q.div >> 1);
        end
    end

    // End of the current period.
    always_comb wrap_o = run_q && (cnt == last);

    // Capture settings while idle and at each period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)               cfg_q <= '0;
        else if (!run_q || wrap_o) cfg_q <= cfg_i;
    end

    // Advance the phase counter while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_q) cnt <= '0;
        else if (wrap_o)      cnt <= '0;
        else                  cnt <= cnt + CNT_W'(1);
    end

    // Registered divided level and output-valid flag, one cycle behind run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= 1'b0;
            live_q <= 1'b0;
        end else begin
            div_q  <= run_q && (cnt < half);
            live_q <= run_q;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt <= last)); // R1
    AST_IDLE_DIV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> !div_q); // R5
endmodule

// File: rtl/gcd_out_shape.sv
// Output shaping: half-cycle stretch on the falling edge, pass-through
// gating, idle level and pad gating.
// Assumes div_q and live_q change only on rising source edges.
module gcd_out_shape (
    input  logic clk,
    input  logic rst_n,
    input  logic div_q,
    input  logic live_q,
    input  logic pass_i,
    input  logic odd_fix_i,
    input  logic off_level,
    input  logic pad_en,
    output logic run_n,
    output logic gclk_o,
    output logic pad_clk_o
);
    logic ext_n;
    logic core;
    logic live_sel;

    // Falling-edge copies: half-cycle stretch and glitch-free bypass gate.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            ext_n <= 1'b0;
            run_n <= 1'b0;
        end else begin
            ext_n <= div_q && odd_fix_i;
            run_n <= live_q;
        end
    end

    // Select bypass or divided waveform, idle level when stopped.
    always_comb begin
        core      = pass_i ? clk : (div_q || ext_n);
        live_sel  = pass_i ? run_n : live_q;
        gclk_o    = live_sel ? core : off_level;
        pad_clk_o = pad_en && gclk_o;
    end
endmodule

// File: rtl/gcd_gen.sv
// Top of the clock generator: run control, phase counter and shaping.
// Assumes all inputs are synchronous to clk.
module gcd_gen (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] div_val,
    input  logic        bin_mode,
    input  logic        duty_fix,
    input  logic        off_level,
    input  logic        pad_en,
    input  logic        gen_en,
    input  logic        stby_req,
    input  logic        stby_run,
    output logic        gclk_o,
    output logic        pad_clk_o,
    output logic        gen_active_o
);
    import gcd_pkg::*;

    gcd_cfg_t cfg;
    logic     run_q, wrap, div_q, live_q, pass, odd_fix, run_n;

    // Bundle the settings for capture.
    always_comb cfg = '{bin_mode: bin_mode, duty_fix: duty_fix, div: DIV_W'(div_val)};

    gcd_run_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .stby_req(stby_req),
        .stby_run(stby_run), .wrap_i(wrap), .run_q(run_q)
    );

    gcd_phase_cnt u_cnt (
        .clk(clk), .rst_n(rst_n), .run_q(run_q), .cfg_i(cfg), .wrap_o(wrap),
        .div_q(div_q), .live_q(live_q), .pass_o(pass), .odd_fix_o(odd_fix)
    );

    gcd_out_shape u_shape (
        .clk(clk), .rst_n(rst_n), .div_q(div_q), .live_q(live_q), .pass_i(pass),
        .odd_fix_i(odd_fix), .off_level(off_level), .pad_en(pad_en),
        .run_n(run_n), .gclk_o(gclk_o), .pad_clk_o(pad_clk_o)
    );

    // Activity stays up until every output stage has gone idle.
    always_comb gen_active_o = run_q || live_q || run_n;

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gen_en) && run_q) |=> gen_active_o); // R7
endmodule

// File: tb/tb_gcd_gen.sv
`timescale 1ns/1ps
module tb_gcd_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] div_val = '0;
    logic        bin_mode = 1'b0, duty_fix = 1'b0, off_level = 1'b1, pad_en = 1'b0;
    logic        gen_en = 1'b0, stby_req = 1'b0, stby_run = 1'b0;
    logic        gclk_o, pad_clk_o, gen_active_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct { int h; int p; string tag; } shape_t;
    shape_t sq[$];

    always #4 clk = ~clk;   // 125 MHz

    gcd_gen dut (
        .clk(clk), .rst_n(rst_n), .div_val(div_val), .bin_mode(bin_mode),
        .duty_fix(duty_fix), .off_level(off_level), .pad_en(pad_en),
        .gen_en(gen_en), .stby_req(stby_req), .stby_run(stby_run),
        .gclk_o(gclk_o), .pad_clk_o(pad_clk_o), .gen_active_o(gen_active_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One sample in every source half cycle.
    task automatic half_samp(output logic v);
        @(posedge clk or negedge clk);
        #2;
        v = gclk_o;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    // Expected shape in half-cycle samples, from the requirements.
    function automatic void expect_shape(input bit bm, input bit fx, input int d,
                                         output int h, output int p);
        if (bm) begin
            h = 2 * (1 << (d % 32));
            p = 2 * h;
        end else if (d <= 1) begin
            h = 1; p = 2;
        end else begin
            h = 2 * (d / 2) + ((fx && (d % 2 == 1)) ? 1 : 0);
            p = 2 * d;
        end
    endfunction

    task automatic stop_gen();
        gen_en = 1'b0;
        while (gen_active_o) tick(1);
    endtask

    // Driver: program, start, queue the expected shape, wait for the monitor.
    task automatic run_shape(input bit bm, input bit fx, input int d, input string tag);
        shape_t s;
        stop_gen();
        bin_mode = bm; duty_fix = fx; div_val = 16'(d);
        gen_en = 1'b1;
        expect_shape(bm, fx, d % 32 + (bm ? 0 : d - d % 32), s.h, s.p);
        s.tag = tag;
        sq.push_back(s);
        wait (sq.size() == 0);
    endtask

    // Monitor: measure one full output period from a rising edge.
    initial begin
        logic v, pv;
        int h, l;
        forever begin
            wait (sq.size() > 0);
            half_samp(pv);
            forever begin
                half_samp(v);
                if (!pv && v) break;
                pv = v;
            end
            h = 1;
            forever begin half_samp(v); if (!v) break; h++; end
            l = 1;
            forever begin half_samp(v); if (v) break; l++; end
            check(h == sq[0].h, {sq[0].tag, " high"}, h, sq[0].h);
            check(h + l == sq[0].p, {sq[0].tag, " period"}, h + l, sq[0].p);
            void'(sq.pop_front());
        end
    end

    // Watchdog.
    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic v;
        int n, ok;
        // R9: reset state
        tick(5);
        check(gen_active_o == 1'b0, "R9 active in reset", gen_active_o, 0);
        check(gclk_o == 1'b1, "R9 idle level in reset", gclk_o, 1);
        rst_n = 1'b1;
        tick(2);
        check(gen_active_o == 1'b0, "R9 active after reset", gen_active_o, 0);
        off_level = 1'b0;

        // R1: binary mode, upper bits ignored
        run_shape(1, 0, 0, "R1 e0");
        run_shape(1, 0, 2, "R1 e2");
        run_shape(1, 0, 16'hFFE3, "R1 e3 upper bits");
        // R2: integer, no correction
        run_shape(0, 0, 5, "R2 N5");
        run_shape(0, 0, 6, "R2 N6");
        run_shape(0, 0, 2, "R2 N2");
        // R4: duty correction
        run_shape(0, 1, 5, "R4 N5 fix");
        run_shape(0, 1, 7, "R4 N7 fix");
        run_shape(0, 1, 4, "R4 N4 fix even");
        // R3: pass-through
        run_shape(0, 0, 0, "R3 div0");
        run_shape(0, 1, 1, "R3 div1");

        // R6: pad gating while running N=5
        run_shape(0, 0, 5, "R6 run");
        pad_en = 1'b0; ok = 1;
        for (int i = 0; i < 40; i++) begin half_samp(v); if (pad_clk_o !== 1'b0) ok = 0; end
        check(ok == 1, "R6 pad off", ok, 1);
        pad_en = 1'b1; ok = 1;
        for (int i = 0; i < 40; i++) begin half_samp(v); if (pad_clk_o !== v) ok = 0; end
        check(ok == 1, "R6 pad follows clock", ok, 1);

        // R7: activity holds after disable until stopped
        stop_gen();
        bin_mode = 1'b1; duty_fix = 1'b0; div_val = 16'd4; gen_en = 1'b1;
        tick(2);
        check(gen_active_o == 1'b1, "R7 active after enable", gen_active_o, 1);
        tick(40);
        gen_en = 1'b0;
        tick(1);
        check(gen_active_o == 1'b1, "R7 active just after disable", gen_active_o, 0 + 1);
        n = 1;
        while (gen_active_o && n < 100) begin tick(1); n++; end
        check(n <= 34, "R7 stop latency cycles", n, 34);
        check(gen_active_o == 1'b0, "R7 inactive after stop", gen_active_o, 0);
        check(gclk_o == 1'b0, "R5 idle low", gclk_o, 0);
        off_level = 1'b1; tick(1);
        check(gclk_o == 1'b1, "R5 idle high", gclk_o, 1);
        pad_en = 1'b0; tick(1);
        check(pad_clk_o == 1'b0, "R6 pad off while idle", pad_clk_o, 0);
        off_level = 1'b0;

        // R10: disable during a high pulse keeps the pulse whole
        bin_mode = 1'b0; div_val = 16'd6; gen_en = 1'b1;
        half_samp(v);
        while (v !== 1'b1) half_samp(v);
        gen_en = 1'b0;
        n = 1;
        forever begin half_samp(v); if (!v) break; n++; end
        check(n == 6, "R10 last pulse width halves", n, 6);
        while (gen_active_o) tick(1);
        check(gclk_o == 1'b0, "R10 rests at idle level", gclk_o, 0);

        // R8: standby stops without run-in-standby
        div_val = 16'd4; gen_en = 1'b1;
        tick(20);
        stby_run = 1'b0; stby_req = 1'b1;
        n = 0;
        while (gen_active_o && n < 50) begin tick(1); n++; end
        check(gen_active_o == 1'b0, "R8 standby stops", gen_active_o, 0);
        ok = 1;
        for (int i = 0; i < 20; i++) begin half_samp(v); if (v !== 1'b0) ok = 0; end
        check(ok == 1, "R8 output quiet in standby", ok, 1);
        // R8: run-in-standby keeps running
        stby_run = 1'b1;
        run_shape(0, 0, 3, "R8 run in standby");
        stby_req = 1'b0;
        stop_gen();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule